// File: doc/BRIEF.md
# Two-Wire Slave Address Decoder with Write-Busy Polling

This block is the address-phase front end of a memory-style slave on a two-wire serial bus. It watches the clock and data lines, finds START and STOP conditions, and shifts in the first byte after each START. That byte is accepted only when its upper nibble matches the fixed device-type code and its target-select field names one of the three internal targets. An accepted byte is acknowledged on the bus. At the same moment the target code and the transfer direction go out, registered, to the data-phase logic downstream.

A write transaction that ends with STOP starts a self-timed nonvolatile write cycle. The length of that cycle is set by the `CYCLE_CLKS` parameter. The default is 5 ms at 50 MHz, and a bench can use a short count. While the cycle runs, the block acknowledges no address at all. A bus master can therefore poll by sending addresses until one is acknowledged. Once the cycle is over, a valid address is acknowledged again and normal operation resumes.

The downstream interface is a plain strobe with no ready input. `txn_valid_o` is high for exactly one cycle per accepted address, and the consumer must take `txn_sel_o` and `txn_rd_o` in that cycle. Those two outputs keep their value until the next accepted address. No back-pressure is possible, because the bus itself cannot be stalled in the address phase.

Top module: `tw_addr_front`

## Requirements
- R1: An address byte whose bits 7..4 differ from 1010b is never acknowledged and produces no strobe.
- R2: Bits 3..1 select the target. Codes 000 (memory array), 010 (control/status register) and 111 (potentiometer block) are valid. All other codes are never acknowledged.
- R3: For each acknowledged address, `txn_valid_o` pulses for one cycle. In that same cycle `txn_sel_o` carries bits 3..1, and `txn_rd_o` carries bit 0 (1 = read, 0 = write).
- R4: The acknowledge is driven by holding `sda_pull_o` high. It rises after the SCL falling edge that ends the 8th bit and is released at the next SCL falling edge.
- R5: An acknowledged write ended by STOP raises `busy_o`. `busy_o` then stays high for exactly `CYCLE_CLKS` clock cycles.
- R6: While `busy_o` is high, no address is acknowledged and no strobe is issued, whether bit 0 is 0 or 1.
- R7: After `busy_o` falls, a valid address is acknowledged again.
- R8: A read transaction ended by STOP does not raise `busy_o`.
- R9: A write aborted by a repeated START, or a write address that was not acknowledged, does not raise `busy_o` at a later STOP.
- R10: After reset, `sda_pull_o`, `busy_o` and `txn_valid_o` are low.
- R11: A repeated START restarts address capture, and the new byte is decoded on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line, already synchronized |
| sda_i | input | 1 | Bus data line as seen on the wire, already synchronized |
| sda_pull_o | output | 1 | High pulls the data line low (acknowledge) |
| busy_o | output | 1 | Nonvolatile write cycle in progress |
| txn_valid_o | output | 1 | One-cycle strobe for an accepted address |
| txn_sel_o | output | 3 | Registered target-select code |
| txn_rd_o | output | 1 | Registered direction, 1 = read |

## Verification
A corrupted shift register or bit counter shows up at the ninth bus clock of the same transaction. The acknowledge appears for a rejected byte or goes missing for an accepted one, and the strobe carries the wrong target code. A stale write-pending flag appears within a few clocks of the next STOP, as a busy window that should not have started or one that is missing. A wrong timer count shows up as a busy window whose length differs from `CYCLE_CLKS`, or as a polling address acknowledged too early.

// File: rtl/tw_addr_pkg.sv
package tw_addr_pkg;
  localparam int ADDR_BITS = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  localparam logic [2:0] TGT_ARRAY = 3'b000;
  localparam logic [2:0] TGT_CSR   = 3'b010;
  localparam logic [2:0] TGT_POT   = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_DATA,
    ST_IGNORE
  } addr_state_e;

  function automatic logic is_target(input logic [2:0] code);
    return (code == TGT_ARRAY) || (code == TGT_CSR) || (code == TGT_POT);
  endfunction
endpackage

// File: rtl/tw_line_cond.sv
module tw_line_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_bit
);
  logic scl_q, scl_qq, sda_q, sda_qq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      scl_qq <= 1'b1;
      sda_q  <= 1'b1;
      sda_qq <= 1'b1;
    end else begin
      scl_q  <= scl_i;
      scl_qq <= scl_q;
      sda_q  <= sda_i;
      sda_qq <= sda_q;
    end
  end

  assign scl_rise  = scl_q & ~scl_qq;
  assign scl_fall  = ~scl_q & scl_qq;
  assign start_det = scl_q & scl_qq & sda_qq & ~sda_q;
  assign stop_det  = scl_q & scl_qq & ~sda_qq & sda_q;
  assign sda_bit   = sda_q;
endmodule

// File: rtl/tw_addr_fsm.sv
module tw_addr_fsm
  import tw_addr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_bit,
  input  logic       busy,
  output logic       sda_pull,
  output logic       txn_valid,
  output logic [2:0] txn_sel,
  output logic       txn_rd,
  output logic       wr_done
);
  localparam int CNT_W = $clog2(ADDR_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_BITS);

  addr_state_e           state;
  logic [ADDR_BITS-1:0]  shreg;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  wr_pend;
  logic                  accept;

  assign accept = (shreg[7:4] == DEV_TYPE) && is_target(shreg[3:1]) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      bit_cnt   <= '0;
      wr_pend   <= 1'b0;
      sda_pull  <= 1'b0;
      txn_valid <= 1'b0;
      txn_sel   <= '0;
      txn_rd    <= 1'b0;
      wr_done   <= 1'b0;
    end else begin
      txn_valid <= 1'b0;
      wr_done   <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        wr_pend  <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
        wr_done  <= wr_pend;
        wr_pend  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise && bit_cnt != LAST_BIT) begin
              shreg   <= {shreg[ADDR_BITS-2:0], sda_bit};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST_BIT) begin
              if (accept) begin
                state     <= ST_ACK;
                sda_pull  <= 1'b1;
                txn_valid <= 1'b1;
                txn_sel   <= shreg[3:1];
                txn_rd    <= shreg[0];
                wr_pend   <= ~shreg[0];
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tw_busy_timer.sv
module tw_busy_timer #(
  parameter int CYCLE_CLKS = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLE_CLKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= CW'(CYCLE_CLKS);
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tw_addr_front.sv
module tw_addr_front #(
  parameter int CYCLE_CLKS = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic       busy_o,
  output logic       txn_valid_o,
  output logic [2:0] txn_sel_o,
  output logic       txn_rd_o
);
  logic scl_rise, scl_fall, start_det, stop_det, sda_bit, wr_done;

  tw_line_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_bit   (sda_bit)
  );

  tw_addr_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_bit   (sda_bit),
    .busy      (busy_o),
    .sda_pull  (sda_pull_o),
    .txn_valid (txn_valid_o),
    .txn_sel   (txn_sel_o),
    .txn_rd    (txn_rd_o),
    .wr_done   (wr_done)
  );

  tw_busy_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wr_done),
    .busy  (busy_o)
  );
endmodule

// File: rtl/tw_addr_front_chk.sv
module tw_addr_front_chk #(
  parameter int CYCLE_CLKS = 250000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull_o,
  input logic       busy_o,
  input logic       txn_valid_o,
  input logic [2:0] txn_sel_o
);
  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  // R2
  sel_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid_o |-> (txn_sel_o == 3'b000 || txn_sel_o == 3'b010 || txn_sel_o == 3'b111));

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid_o |=> !txn_valid_o);

  // R4
  ack_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> txn_valid_o);

  // R6
  busy_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !txn_valid_o);

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_len == 32'(CYCLE_CLKS)));
endmodule

bind tw_addr_front tw_addr_front_chk #(.CYCLE_CLKS(CYCLE_CLKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sda_pull_o  (sda_pull_o),
  .busy_o      (busy_o),
  .txn_valid_o (txn_valid_o),
  .txn_sel_o   (txn_sel_o)
);

// File: tb/tw_addr_front_bench.sv
module tw_addr_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int CYC = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull_o, busy_o, txn_valid_o, txn_rd_o;
  logic [2:0] txn_sel_o;
  wire sda_bus = m_sda & ~sda_pull_o;

  int checks = 0;
  int fails = 0;
  int strobes = 0;
  logic [2:0] last_sel = '0;
  logic last_rd = 1'b0;
  int busy_len = 0;
  int last_busy_len = 0;
  logic busy_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_addr_front #(.CYCLE_CLKS(CYC)) u_tw_addr_front (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull_o), .busy_o(busy_o), .txn_valid_o(txn_valid_o),
    .txn_sel_o(txn_sel_o), .txn_rd_o(txn_rd_o)
  );

  always @(negedge clk) begin
    if (txn_valid_o) begin
      strobes  <= strobes + 1;
      last_sel <= txn_sel_o;
      last_rd  <= txn_rd_o;
    end
    busy_d <= busy_o;
    if (busy_o) busy_len <= busy_len + 1;
    else begin
      if (busy_d) last_busy_len <= busy_len;
      busy_len <= 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hw();
    scl = 1'b1; hw();
    m_sda = 1'b0; hw();
    scl = 1'b0; hw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hw();
    scl = 1'b1; hw();
    m_sda = 1'b1; hw();
    hw();
  endtask

  // Sends 8 address bits, returns the sampled ACK and the pull state after release.
  task automatic send_addr(input logic [7:0] a, output logic ack, output logic pull_after);
    for (int i = 7; i >= 0; i--) begin
      m_sda = a[i]; hw();
      scl = 1'b1; hw();
      scl = 1'b0;
    end
    m_sda = 1'b1; hw();
    scl = 1'b1; hw();
    ack = ~sda_bus;
    scl = 1'b0; hw();
    pull_after = sda_pull_o;
  endtask

  typedef struct packed {
    logic [7:0] addr;
    logic       ack;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'b1010_000_1, 1'b1},
    '{8'b1010_010_1, 1'b1},
    '{8'b1010_111_1, 1'b1},
    '{8'b1010_001_1, 1'b0},
    '{8'b1010_011_0, 1'b0},
    '{8'b1010_100_1, 1'b0},
    '{8'b1010_101_1, 1'b0},
    '{8'b1010_110_0, 1'b0},
    '{8'b1011_000_1, 1'b0},
    '{8'b0010_111_0, 1'b0}
  };

  logic done = 1'b0;

  initial begin
    logic ack, pa;
    int s0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 pull", int'(sda_pull_o), 0);
    chk("R10 busy", int'(busy_o), 0);
    chk("R10 valid", int'(txn_valid_o), 0);
    rst_n = 1'b1;
    hw();

    for (int v = 0; v < NVEC; v++) begin
      s0 = strobes;
      bus_start();
      send_addr(VECS[v].addr, ack, pa);
      chk("R1/R2 ack", int'(ack), int'(VECS[v].ack));
      chk("R3 strobe count", strobes - s0, int'(VECS[v].ack));
      chk("R4 release", int'(pa), 0);
      if (VECS[v].ack) begin
        chk("R3 sel", int'(last_sel), int'(VECS[v].addr[3:1]));
        chk("R3 rd", int'(last_rd), int'(VECS[v].addr[0]));
      end
      bus_stop();
      // R8 reads, R9 nacked writes: no busy
      chk("R8/R9 no busy", int'(busy_o), 0);
    end

    // R5 write then STOP starts busy
    bus_start();
    send_addr(8'b1010_111_0, ack, pa);
    chk("R5 write ack", int'(ack), 1);
    chk("R3 write rd", int'(last_rd), 0);
    bus_stop();
    chk("R5 busy set", int'(busy_o), 1);
    // R6 polling with write and read
    s0 = strobes;
    bus_start();
    send_addr(8'b1010_000_0, ack, pa);
    chk("R6 poll write nack", int'(ack), 0);
    bus_start();
    send_addr(8'b1010_010_1, ack, pa);
    chk("R6 poll read nack", int'(ack), 0);
    bus_stop();
    chk("R6 no strobe", strobes - s0, 0);
    while (busy_o) @(negedge clk);
    hw();
    chk("R5 busy length", last_busy_len, CYC);
    // R7 resume
    bus_start();
    send_addr(8'b1010_010_1, ack, pa);
    chk("R7 ack after busy", int'(ack), 1);
    bus_stop();
    chk("R7 read no busy", int'(busy_o), 0);

    // R9/R11 write aborted by repeated START, then a read
    bus_start();
    send_addr(8'b1010_010_0, ack, pa);
    chk("R9 write ack", int'(ack), 1);
    bus_start();
    send_addr(8'b1010_000_1, ack, pa);
    chk("R11 restart ack", int'(ack), 1);
    chk("R11 sel", int'(last_sel), 0);
    chk("R11 rd", int'(last_rd), 1);
    bus_stop();
    chk("R9 no busy after abort", int'(busy_o), 0);

    // R11 restart into an invalid byte
    bus_start();
    send_addr(8'b1010_111_1, ack, pa);
    bus_start();
    send_addr(8'b1110_111_1, ack, pa);
    chk("R11 restart nack", int'(ack), 0);
    bus_stop();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule